// File: doc/BRIEF.md
# Plug-and-Play Initiation Key Detector with Extended Field-Programming Key

This block sits behind the ISA address decode of a plug-and-play adapter card. It watches byte writes to the plug-and-play address port and compares them against the initiation key. The key is a fixed 32-byte sequence produced by an 8-bit shift register with feedback. The block reports its protocol state to the rest of the card: waiting for the key, sleeping, or configuring. It also raises a programming-enable flag and presents a fixed read-data port address when the card may rewrite its own configuration memory.

The switch inputs are sampled during reset. If the mode pin is low and all five switches are high, the card is in software-write mode. In that mode the 32 key bytes alone do nothing. One more byte of value 0x9C must follow them. That extra byte sends the card straight into the configuration state, sets programming enable and selects read-data port 0x203. In every other mode, the plain 32-byte key moves the card to the sleep state.

Top module: `pnp_key_detector`

## Requirements
- R1: While and after reset, `state_o` is WAIT (2'b00), `prog_en` is 0 and `rd_port` is 0. The state encoding is WAIT=2'b00, SLEEP=2'b01, CONFIG=2'b10.
- R2: A byte counts as a key byte only when `wr_stb` is high, `aen` is low and `addr` equals 12'h279. Any other write leaves the comparison progress unchanged.
- R3: The key starts at 8'h6A. Each next byte is the previous one shifted right by one bit, with the new bit 7 equal to the XOR of the old bits 0 and 1. The key is 32 bytes long.
- R4: Outside software-write mode, 32 matching key bytes move `state_o` to SLEEP in the cycle after the 32nd write. `prog_en` stays 0. A following 0x9C byte has no effect.
- R5: Software-write mode is selected when `mode_pnp` is 0 and `sw_sel` is 5'b11111, sampled while `rst` is high. Changes to these pins after reset do not change the mode.
- R6: In software-write mode, 32 matching bytes leave the state at WAIT. A 33rd key byte of 8'h9C then sets `state_o` to CONFIG, `prog_en` to 1 and `rd_port` to 12'h203, in the cycle after that write.
- R7: A key byte that does not match the expected byte restarts the comparison. If that byte equals 8'h6A, it is taken as the first byte of a new attempt.
- R8: Once the state is SLEEP or CONFIG, key writes are ignored. The state, `prog_en` and `rd_port` hold until the next reset.
- R9: In software-write mode, a 33rd byte other than 8'h9C keeps the state at WAIT and restarts the comparison. The restart follows the rule of R7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high bus reset |
| wr_stb | input | 1 | One-cycle I/O write strobe |
| aen | input | 1 | Address enable; high marks a DMA cycle |
| addr | input | 12 | I/O address |
| wdata | input | 8 | Write data byte |
| mode_pnp | input | 1 | 1 selects plug-and-play mode, 0 selects legacy mode |
| sw_sel | input | 5 | Legacy configuration switches |
| state_o | output | 2 | Protocol state |
| prog_en | output | 1 | Configuration-memory programming enable |
| rd_port | output | 12 | Preset read-data port address, 0 when not preset |

## Verification
The bench targets four corner cases.
- **Restart on 0x6A.** A partial key is followed by a full key. If the design dropped the restart-on-0x6A rule, it would miss the second key. If it counted the restart wrongly, it would leave WAIT one byte early or late.
- **Extended key boundary.** The 33rd byte is tested both as 0x9C and as a wrong value. A design that ended the extended key on the 32nd byte would reach CONFIG too soon. A design that stayed armed at the tail would accept 0x9C after a wrong byte.
- **Write qualification.** Writes with `aen` high or to a different address are placed in the middle of a key. A design that did not qualify these writes would abort or skip ahead.
- **Mode latching.** The mode pins are changed after reset. A design that sampled them live would enter the wrong branch.

// File: rtl/pnp_key_pkg.sv
package pnp_key_pkg;

    typedef enum logic [1:0] {
        ST_WAIT   = 2'b00,
        ST_SLEEP  = 2'b01,
        ST_CONFIG = 2'b10
    } pnp_state_e;

    localparam logic [7:0] KEY_SEED = 8'h6A;
    localparam logic [7:0] EXT_BYTE = 8'h9C;

    // One step of the key shift register: shift right, feed bit0^bit1 into bit 7.
    function automatic logic [7:0] key_step(input logic [7:0] cur);
        return {cur[0] ^ cur[1], cur[7:1]};
    endfunction

endpackage

// File: rtl/pnp_key_qualify.sv
module pnp_key_qualify #(
    parameter int          ADDR_W   = 12,
    parameter logic [11:0] KEY_PORT = 12'h279
) (
    input  logic              wr_stb,
    input  logic              aen,
    input  logic [ADDR_W-1:0] addr,
    output logic              key_wr
);
    localparam logic [ADDR_W-1:0] PORT = ADDR_W'(KEY_PORT);

    always_comb key_wr = wr_stb && !aen && (addr == PORT);
endmodule

// File: rtl/pnp_key_tracker.sv
module pnp_key_tracker
    import pnp_key_pkg::*;
#(
    parameter int KEY_LEN = 32
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       key_wr,
    input  logic       armed,
    input  logic       sw_mode,
    input  logic [7:0] wdata,
    output logic       hit_key,
    output logic       hit_ext
);
    localparam int CNT_W = $clog2(KEY_LEN + 1);
    localparam logic [CNT_W-1:0] TAIL = CNT_W'(KEY_LEN);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(KEY_LEN - 1);

    logic [CNT_W-1:0] cnt;
    logic [7:0]       expect_q;
    logic             take;
    logic             byte_ok;

    always_comb begin
        take    = key_wr && armed;
        byte_ok = take && (cnt < TAIL) && (wdata == expect_q);
        hit_key = byte_ok && (cnt == LAST);
        hit_ext = take && sw_mode && (cnt == TAIL) && (wdata == EXT_BYTE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt      <= '0;
            expect_q <= KEY_SEED;
        end else if (take) begin
            if (hit_key) begin
                cnt      <= sw_mode ? TAIL : '0;
                expect_q <= KEY_SEED;
            end else if (byte_ok) begin
                cnt      <= cnt + 1'b1;
                expect_q <= key_step(expect_q);
            end else if (hit_ext) begin
                cnt      <= '0;
                expect_q <= KEY_SEED;
            end else if (wdata == KEY_SEED) begin
                cnt      <= CNT_W'(1);
                expect_q <= key_step(KEY_SEED);
            end else begin
                cnt      <= '0;
                expect_q <= KEY_SEED;
            end
        end
    end
endmodule

// File: rtl/pnp_key_fsm.sv
module pnp_key_fsm
    import pnp_key_pkg::*;
#(
    parameter int          ADDR_W     = 12,
    parameter logic [11:0] RDP_PRESET = 12'h203
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_pnp,
    input  logic [4:0]        sw_sel,
    input  logic              hit_key,
    input  logic              hit_ext,
    output logic              armed,
    output logic              sw_mode,
    output pnp_state_e        state,
    output logic              prog_en,
    output logic [ADDR_W-1:0] rd_port
);
    always_comb armed = (state == ST_WAIT);

    always_ff @(posedge clk) begin
        if (rst) begin
            sw_mode <= !mode_pnp && (&sw_sel);
            state   <= ST_WAIT;
            prog_en <= 1'b0;
            rd_port <= '0;
        end else if (armed) begin
            if (hit_ext) begin
                state   <= ST_CONFIG;
                prog_en <= 1'b1;
                rd_port <= ADDR_W'(RDP_PRESET);
            end else if (hit_key && !sw_mode) begin
                state <= ST_SLEEP;
            end
        end
    end
endmodule

// File: rtl/pnp_key_detector.sv
module pnp_key_detector
    import pnp_key_pkg::*;
#(
    parameter int          ADDR_W     = 12,
    parameter int          KEY_LEN    = 32,
    parameter logic [11:0] KEY_PORT   = 12'h279,
    parameter logic [11:0] RDP_PRESET = 12'h203
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_stb,
    input  logic              aen,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    input  logic              mode_pnp,
    input  logic [4:0]        sw_sel,
    output logic [1:0]        state_o,
    output logic              prog_en,
    output logic [ADDR_W-1:0] rd_port
);
    logic       key_wr;
    logic       armed;
    logic       sw_mode;
    logic       hit_key;
    logic       hit_ext;
    pnp_state_e state;

    pnp_key_qualify #(.ADDR_W(ADDR_W), .KEY_PORT(KEY_PORT)) u_qual (
        .wr_stb (wr_stb),
        .aen    (aen),
        .addr   (addr),
        .key_wr (key_wr)
    );

    pnp_key_tracker #(.KEY_LEN(KEY_LEN)) u_track (
        .clk     (clk),
        .rst     (rst),
        .key_wr  (key_wr),
        .armed   (armed),
        .sw_mode (sw_mode),
        .wdata   (wdata),
        .hit_key (hit_key),
        .hit_ext (hit_ext)
    );

    pnp_key_fsm #(.ADDR_W(ADDR_W), .RDP_PRESET(RDP_PRESET)) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .mode_pnp (mode_pnp),
        .sw_sel   (sw_sel),
        .hit_key  (hit_key),
        .hit_ext  (hit_ext),
        .armed    (armed),
        .sw_mode  (sw_mode),
        .state    (state),
        .prog_en  (prog_en),
        .rd_port  (rd_port)
    );

    always_comb state_o = state;
endmodule

// File: rtl/pnp_key_detector_chk.sv
module pnp_key_detector_chk #(
    parameter int          ADDR_W     = 12,
    parameter logic [11:0] KEY_PORT   = 12'h279,
    parameter logic [11:0] RDP_PRESET = 12'h203
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_stb,
    input logic              aen,
    input logic [ADDR_W-1:0] addr,
    input logic [7:0]        wdata,
    input logic [1:0]        state_o,
    input logic              prog_en,
    input logic [ADDR_W-1:0] rd_port
);
    // R1
    reset_state_chk: assert property (@(posedge clk)
        $past(rst) |-> (state_o == 2'b00 && !prog_en && rd_port == '0));

    // R2
    leave_wait_qualified_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(state_o) == 2'b00 && state_o != 2'b00) |->
            $past(wr_stb && !aen && addr == ADDR_W'(KEY_PORT)));

    // R6
    prog_with_config_chk: assert property (@(posedge clk) disable iff (rst)
        prog_en |-> (state_o == 2'b10 && rd_port == ADDR_W'(RDP_PRESET)));

    // R6
    prog_rise_ext_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(prog_en) |-> $past(wdata) == 8'h9C);

    // R4
    sleep_no_prog_chk: assert property (@(posedge clk) disable iff (rst)
        state_o == 2'b01 |-> (!prog_en && rd_port == '0));

    // R8
    hold_after_key_chk: assert property (@(posedge clk) disable iff (rst)
        state_o != 2'b00 |=> ($stable(state_o) && $stable(prog_en) && $stable(rd_port)));
endmodule

bind pnp_key_detector pnp_key_detector_chk #(
    .ADDR_W(ADDR_W), .KEY_PORT(KEY_PORT), .RDP_PRESET(RDP_PRESET)
) u_chk (
    .clk(clk), .rst(rst), .wr_stb(wr_stb), .aen(aen), .addr(addr),
    .wdata(wdata), .state_o(state_o), .prog_en(prog_en), .rd_port(rd_port)
);

// File: tb/pnp_key_detector_bench.sv
module pnp_key_detector_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_stb = 1'b0;
    logic        aen = 1'b0;
    logic [11:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic        mode_pnp = 1'b1;
    logic [4:0]  sw_sel = 5'b11111;
    logic [1:0]  state_o;
    logic        prog_en;
    logic [11:0] rd_port;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] key [32];

    always #5 clk = ~clk;

    pnp_key_detector u_pnp_key_detector (
        .clk(clk), .rst(rst), .wr_stb(wr_stb), .aen(aen), .addr(addr),
        .wdata(wdata), .mode_pnp(mode_pnp), .sw_sel(sw_sel),
        .state_o(state_o), .prog_en(prog_en), .rd_port(rd_port)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic expect_out(input string req, input logic [1:0] st,
                              input logic pe, input logic [11:0] rp);
        check(req, {20'd0, st, pe, 9'd0}, {20'd0, state_o, prog_en, 9'd0});
        check(req, 32'(rp), 32'(rd_port));
    endtask

    task automatic do_reset(input logic mp, input logic [4:0] sw);
        @(negedge clk);
        mode_pnp = mp; sw_sel = sw; rst = 1'b1;
        @(negedge clk); @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic put(input logic [11:0] a, input logic e, input logic [7:0] d);
        wr_stb = 1'b1; addr = a; aen = e; wdata = d;
        @(negedge clk);
        wr_stb = 1'b0; aen = 1'b0;
        @(negedge clk);
    endtask

    task automatic put_key(input int first, input int last);
        for (int i = first; i <= last; i++) put(12'h279, 1'b0, key[i]);
    endtask

    task automatic t_reset;
        do_reset(1'b1, 5'b11111);
        check("R1 state", 32'(state_o), 32'd0);
        check("R1 prog_en", 32'(prog_en), 32'd0);
        check("R1 rd_port", 32'(rd_port), 32'd0);
    endtask

    task automatic t_normal_key;
        do_reset(1'b1, 5'b11111);
        put_key(0, 30);
        check("R3 wait before byte 32", 32'(state_o), 32'd0);
        put_key(31, 31);
        check("R4 sleep after 32", 32'(state_o), 32'd1);
        check("R4 no prog", 32'(prog_en), 32'd0);
        put(12'h279, 1'b0, 8'h9C);
        expect_out("R4 9C ignored", 2'b01, 1'b0, 12'h000);
        put_key(0, 31);
        expect_out("R8 key ignored in sleep", 2'b01, 1'b0, 12'h000);
    endtask

    task automatic t_filter;
        do_reset(1'b1, 5'b00000);
        put_key(0, 15);
        put(12'h279, 1'b1, 8'h00);
        put(12'h27A, 1'b0, 8'h00);
        put(12'h679, 1'b0, 8'h00);
        put_key(16, 31);
        check("R2 unqualified writes ignored", 32'(state_o), 32'd1);
    endtask

    task automatic t_restart;
        do_reset(1'b1, 5'b11111);
        put_key(0, 9);
        put(12'h279, 1'b0, 8'h00);
        put_key(10, 31);
        check("R7 mismatch aborts", 32'(state_o), 32'd0);
        put_key(0, 5);
        put_key(0, 30);
        check("R7 restart at 6A not early", 32'(state_o), 32'd0);
        put_key(31, 31);
        check("R7 restart at 6A matches", 32'(state_o), 32'd1);
    endtask

    task automatic t_sw_key;
        do_reset(1'b0, 5'b11111);
        put_key(0, 31);
        expect_out("R6 32 bytes stay wait", 2'b00, 1'b0, 12'h000);
        put(12'h279, 1'b0, 8'h9C);
        expect_out("R6 ext key config", 2'b10, 1'b1, 12'h203);
        put(12'h279, 1'b0, 8'h6A);
        put_key(0, 31);
        expect_out("R8 config holds", 2'b10, 1'b1, 12'h203);
        do_reset(1'b0, 5'b11111);
        expect_out("R1 reset clears config", 2'b00, 1'b0, 12'h000);
    endtask

    task automatic t_sw_wrong33;
        do_reset(1'b0, 5'b11111);
        put_key(0, 31);
        put(12'h279, 1'b0, 8'h9D);
        expect_out("R9 wrong 33rd stays wait", 2'b00, 1'b0, 12'h000);
        put(12'h279, 1'b0, 8'h9C);
        expect_out("R9 9C after wrong is no match", 2'b00, 1'b0, 12'h000);
        put_key(0, 31);
        put(12'h279, 1'b0, 8'h6A);
        put_key(1, 31);
        put(12'h279, 1'b0, 8'h9C);
        expect_out("R9 6A at tail restarts", 2'b10, 1'b1, 12'h203);
    endtask

    task automatic t_latch;
        do_reset(1'b1, 5'b11111);
        mode_pnp = 1'b0;
        put_key(0, 31);
        check("R5 mode latched normal", 32'(state_o), 32'd1);
        do_reset(1'b0, 5'b11111);
        sw_sel = 5'b01111;
        put_key(0, 31);
        check("R5 mode latched sw", 32'(state_o), 32'd0);
        put(12'h279, 1'b0, 8'h9C);
        check("R5 latched sw enters config", 32'(state_o), 32'd2);
        do_reset(1'b0, 5'b11110);
        put_key(0, 31);
        check("R5 legacy non-11111 is normal", 32'(state_o), 32'd1);
    endtask

    initial begin
        key[0] = 8'h6A;
        for (int i = 1; i < 32; i++)
            key[i] = {key[i-1][0] ^ key[i-1][1], key[i-1][7:1]};
        check("R3 second key byte", 32'(key[1]), 32'hB5);
        t_reset();
        t_normal_key();
        t_filter();
        t_restart();
        t_sw_key();
        t_sw_wrong33();
        t_latch();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #1000000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule